// File: doc/BRIEF.md
# Cascadable Priority Line Encoder

This block turns a set of request lines into the binary index of the most significant request that is asserted. It is built from identical eight-line slices. Each slice has an active-low enable input, a chain output that hands the enable down to the next less significant slice, and a group-select output that says the slice has found a request. The top module chains two slices into a sixteen-line encoder. The upper slice's group-select becomes the most significant code bit, and the lower three code bits are the AND of the slices' active-low codes.

All request lines, code bits, the enable input and the group-select output are active low. A request is asserted when its bit is 0, and a code output of value k is presented as the bitwise inverse of k. The block is purely combinational. It is meant for keypads, interrupt lines or arbitration requests whose source has already been settled. Debouncing, capture of presses and detection of more than one request are left to the surrounding logic.

Top module: `prio_enc_cascade`

## Requirements
- R1: While enabled and with at least one request asserted, `code_n` equals the bitwise inverse of the index of the asserted request it selects. A request is asserted when its `req_n` bit is 0.
- R2: When several requests are asserted, the highest-numbered one sets the code. Asserted requests below it have no effect on any output.
- R3: While `grp_en_n` is 1, the outputs are held inactive whatever `req_n` carries: `code_n` is all ones, `grp_sel_n` is 1 and `chain_out_n` is 1.
- R4: While `grp_en_n` is 0 and no request is asserted, `code_n` is all ones, `grp_sel_n` is 1 and `chain_out_n` is 0.
- R5: While `grp_en_n` is 0 and any request is asserted, `grp_sel_n` is 0 and `chain_out_n` is 1.
- R6: While enabled, any asserted request in the upper slice (indices 8 to 15) drives `code_n[3]` to 0. In that case no request in the lower slice (indices 0 to 7) changes the code.
- R7: While enabled, with no upper-slice request and at least one lower-slice request, `code_n[3]` is 1 and `code_n[2:0]` is the inverse of the highest asserted lower index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp_en_n | input | 1 | Active-low enable of the whole encoder; feeds the most significant slice |
| req_n | input | 16 | Active-low request lines, bit i is request i |
| code_n | output | 4 | Active-low index of the highest asserted request |
| grp_sel_n | output | 1 | Low when the enabled encoder has found any request |
| chain_out_n | output | 1 | Low when enabled with no request asserted; enables a further encoder |

## Verification
The checker re-evaluates several properties every time an input changes. The disabled state is held inactive. The idle state drives the chain output low. The group-select and chain outputs agree with the presence of any request. The selected request is asserted and no request above it is. The top code bit follows the upper slice. The checker only confirms that outputs are consistent with the inputs. The bench's scenarios show that the exact code values are right, using single requests, competing pairs across the slice boundary and a full sweep of all 65,536 request patterns against an index-search model.

// File: rtl/prio_enc_pkg.sv
// Package: shared defaults for the cascadable priority encoder.
// Assumes slices hold a power-of-two number of lines and at least two
// slices are chained.
package prio_enc_pkg;
    localparam int unsigned DEF_SLICE_LINES = 8;
    localparam int unsigned DEF_SLICES      = 2;

    // Combined outputs of one encoder stage, all active low.
    typedef struct packed {
        logic grp_sel_n;
        logic chain_n;
    } stage_flags_t;
endpackage

// File: rtl/prio_highest_find.sv
// Module: prio_highest_find
// Finds the highest-numbered set bit of an active-high vector. Purely
// combinational. Assumes IDX_W is wide enough to hold LINES-1.
module prio_highest_find #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] act,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan upward so that a later (higher) set bit overrides earlier ones.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < int'(LINES); i++) begin
            if (act[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_enc_slice.sv
// Module: prio_enc_slice
// One active-low priority encoder slice with an enable input, a chain output
// for the next less significant slice and a group-select output.
// Assumes LINES is a power of two.
module prio_enc_slice #(
    parameter int unsigned LINES  = 8,
    localparam int unsigned CODE_W = $clog2(LINES)
) (
    input  logic              en_n,
    input  logic [LINES-1:0]  req_n,
    output logic [CODE_W-1:0] code_n,
    output logic              gs_n,
    output logic              chain_n
);
    logic              found;
    logic [CODE_W-1:0] top_idx;
    logic [LINES-1:0]  act;

    // Convert the active-low requests to active-high for the search.
    assign act = ~req_n;

    prio_highest_find #(
        .LINES (LINES),
        .IDX_W (CODE_W)
    ) i_find (
        .act (act),
        .hit (found),
        .idx (top_idx)
    );

    // Drive the code and handshake outputs from the enable and search result.
    always_comb begin
        if (en_n) begin
            code_n  = '1;
            gs_n    = 1'b1;
            chain_n = 1'b1;
        end else if (found) begin
            code_n  = ~top_idx;
            gs_n    = 1'b0;
            chain_n = 1'b1;
        end else begin
            code_n  = '1;
            gs_n    = 1'b1;
            chain_n = 1'b0;
        end
    end
endmodule

// File: rtl/prio_enc_cascade.sv
// Module: prio_enc_cascade
// Chains SLICES encoder slices. The most significant slice takes the external
// enable, and each slice's chain output enables the slice below it. The high
// code bits come from the group-selects of the slices, and the low code bits
// are the AND of all slice codes. Assumes SLICES >= 2 and a power of two.
module prio_enc_cascade
    import prio_enc_pkg::*;
#(
    parameter int unsigned SLICE_LINES = DEF_SLICE_LINES,
    parameter int unsigned SLICES      = DEF_SLICES,
    localparam int unsigned TOTAL   = SLICE_LINES * SLICES,
    localparam int unsigned SLICE_W = $clog2(SLICE_LINES),
    localparam int unsigned SEL_W   = $clog2(SLICES),
    localparam int unsigned CODE_W  = SLICE_W + SEL_W
) (
    input  logic              grp_en_n,
    input  logic [TOTAL-1:0]  req_n,
    output logic [CODE_W-1:0] code_n,
    output logic              grp_sel_n,
    output logic              chain_out_n
);
    logic [SLICES-1:0]  en_n;
    logic [SLICES-1:0]  gs_n;
    logic [SLICES-1:0]  eo_n;
    logic [SLICE_W-1:0] sc_n [SLICES];
    logic [SLICE_W-1:0] low_n;
    logic [SEL_W-1:0]   high_n;
    stage_flags_t       flags;

    // The top slice takes the external enable; each lower slice takes the chain above.
    assign en_n[SLICES-1] = grp_en_n;

    for (genvar s = 0; s < int'(SLICES); s++) begin : g_slice
        if (s < int'(SLICES) - 1) begin : g_link
            assign en_n[s] = eo_n[s+1];
        end
        prio_enc_slice #(
            .LINES (SLICE_LINES)
        ) i_slice (
            .en_n    (en_n[s]),
            .req_n   (req_n[s*SLICE_LINES +: SLICE_LINES]),
            .code_n  (sc_n[s]),
            .gs_n    (gs_n[s]),
            .chain_n (eo_n[s])
        );
    end

    // Merge the low code bits: inactive slices present all ones.
    always_comb begin
        low_n = '1;
        for (int s = 0; s < int'(SLICES); s++) begin
            low_n = low_n & sc_n[s];
        end
    end

    // Build the high code bits from the group-select of the one active slice.
    always_comb begin
        high_n = '1;
        for (int k = 0; k < int'(SEL_W); k++) begin
            for (int s = 0; s < int'(SLICES); s++) begin
                if (((s >> k) & 1) == 1) begin
                    high_n[k] = high_n[k] & gs_n[s];
                end
            end
        end
    end

    // Combine the handshake outputs of the whole chain.
    always_comb begin
        flags.grp_sel_n = &gs_n;
        flags.chain_n   = eo_n[0];
    end

    assign code_n      = {high_n, low_n};
    assign grp_sel_n   = flags.grp_sel_n;
    assign chain_out_n = flags.chain_n;
endmodule

// File: rtl/prio_enc_cascade_chk.sv
// Module: prio_enc_cascade_chk
// Checker bound to prio_enc_cascade. It watches only the top-level ports and
// re-checks the properties whenever any of them changes.
module prio_enc_cascade_chk #(
    parameter int unsigned SLICE_LINES = 8,
    parameter int unsigned SLICES      = 2,
    localparam int unsigned TOTAL  = SLICE_LINES * SLICES,
    localparam int unsigned CODE_W = $clog2(TOTAL)
) (
    input logic              grp_en_n,
    input logic [TOTAL-1:0]  req_n,
    input logic [CODE_W-1:0] code_n,
    input logic              grp_sel_n,
    input logic              chain_out_n
);
    logic              any_req;
    logic              upper_req;
    logic [CODE_W-1:0] sel;
    logic [TOTAL-1:0]  above;

    assign any_req   = ~(&req_n);
    assign upper_req = ~(&req_n[TOTAL-1 -: SLICE_LINES]);
    assign sel       = ~code_n;
    assign above     = (~req_n) >> sel;

    // Evaluate the port relations every time the inputs or outputs move.
    always_comb begin
        if (grp_en_n) begin
            assert_disabled_quiet_R3: assert (code_n == '1 && grp_sel_n && chain_out_n)
                else $error("R3 disabled outputs not inactive");
        end
        if (!grp_en_n && !any_req) begin
            assert_idle_chain_low_R4: assert (code_n == '1 && grp_sel_n && !chain_out_n)
                else $error("R4 idle outputs wrong");
        end
        if (!grp_en_n && any_req) begin
            assert_found_flags_R5: assert (!grp_sel_n && chain_out_n)
                else $error("R5 group/chain flags wrong");
            assert_selected_is_top_R1: assert (above == TOTAL'(1))
                else $error("R1/R2 selected request not highest asserted");
        end
        if (!grp_en_n && upper_req) begin
            assert_upper_bit_low_R6: assert (!code_n[CODE_W-1])
                else $error("R6 upper slice bit not driven low");
        end
        if (!grp_en_n && !upper_req && any_req) begin
            assert_lower_bit_high_R7: assert (code_n[CODE_W-1])
                else $error("R7 lower-only request sets top bit");
        end
    end
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(
    .SLICE_LINES (SLICE_LINES),
    .SLICES      (SLICES)
) i_prio_enc_cascade_chk (
    .grp_en_n    (grp_en_n),
    .req_n       (req_n),
    .code_n      (code_n),
    .grp_sel_n   (grp_sel_n),
    .chain_out_n (chain_out_n)
);

// File: tb/test_prio_enc_cascade.sv
// Directed bench for prio_enc_cascade. Inputs are driven after the rising
// edge and outputs are sampled at the falling edge.
module test_prio_enc_cascade;
    logic        clk = 1'b0;
    logic        grp_en_n;
    logic [15:0] req_n;
    logic [3:0]  code_n;
    logic        grp_sel_n;
    logic        chain_out_n;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    prio_enc_cascade i_prio_enc_cascade (
        .grp_en_n    (grp_en_n),
        .req_n       (req_n),
        .code_n      (code_n),
        .grp_sel_n   (grp_sel_n),
        .chain_out_n (chain_out_n)
    );

    // Model: search for the highest asserted request index.
    function automatic logic [5:0] model(input logic en_n, input logic [15:0] r_n);
        logic [3:0] c;
        logic gs, ch;
        c = 4'hF; gs = 1'b1; ch = 1'b1;
        if (!en_n) begin
            ch = 1'b0;
            for (int i = 0; i < 16; i++) begin
                if (!r_n[i]) begin
                    c = ~4'(i); gs = 1'b0; ch = 1'b1;
                end
            end
        end
        return {c, gs, ch};
    endfunction

    // Drive one pattern, wait to the falling edge and compare with the model.
    task automatic apply_check(input string tag, input logic en_n, input logic [15:0] r_n);
        logic [5:0] exp, act;
        @(posedge clk);
        #1;
        grp_en_n = en_n;
        req_n    = r_n;
        @(negedge clk);
        exp = model(en_n, r_n);
        act = {code_n, grp_sel_n, chain_out_n};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s en_n=%b req_n=%h actual code/gs/chain=%h/%b/%b expected %h/%b/%b",
                     tag, en_n, r_n, act[5:2], act[1], act[0], exp[5:2], exp[1], exp[0]);
        end
    endtask

    // Initial quiet state: disabled with no requests (R3).
    task automatic t_reset_state();
        apply_check("R3 initial", 1'b1, 16'hFFFF);
    endtask

    // Disabled encoder ignores every request (R3).
    task automatic t_disabled();
        apply_check("R3 disabled all", 1'b1, 16'h0000);
        apply_check("R3 disabled upper", 1'b1, 16'h7FFF);
        apply_check("R3 disabled lower", 1'b1, 16'hFFFE);
        apply_check("R3 disabled mixed", 1'b1, 16'hA5C3);
    endtask

    // Enabled with nothing asserted: chain output low (R4).
    task automatic t_idle();
        apply_check("R4 idle", 1'b0, 16'hFFFF);
    endtask

    // Each single request gives its own inverted index (R1, R5).
    task automatic t_single();
        for (int i = 0; i < 16; i++) begin
            apply_check("R1 R5 single", 1'b0, ~(16'h1 << i));
        end
    endtask

    // Competing requests inside one slice (R2).
    task automatic t_priority();
        apply_check("R2 pair 6,7", 1'b0, ~16'h00C0);
        apply_check("R2 low all", 1'b0, 16'hFF00);
        apply_check("R2 pair 9,14", 1'b0, ~16'h4200);
        apply_check("R2 all", 1'b0, 16'h0000);
    endtask

    // Upper slice overrides lower slice (R6).
    task automatic t_cascade_override();
        apply_check("R6 8 over 7", 1'b0, ~16'h0180);
        apply_check("R6 15 over all low", 1'b0, ~16'h80FF);
        apply_check("R6 8 over 0", 1'b0, ~16'h0101);
    endtask

    // Lower slice alone sets bit 3 high (R7).
    task automatic t_lower_only();
        apply_check("R7 lower 5,2", 1'b0, ~16'h0024);
        apply_check("R7 lower 7", 1'b0, ~16'h0080);
    endtask

    // Every request pattern while enabled (R1, R2, R5, R6, R7).
    task automatic t_sweep();
        for (int p = 0; p < 65536; p++) begin
            apply_check("R2 sweep", 1'b0, 16'(p));
        end
    endtask

    initial begin
        grp_en_n = 1'b1;
        req_n    = 16'hFFFF;
        t_reset_state();
        t_disabled();
        t_idle();
        t_single();
        t_priority();
        t_cascade_override();
        t_lower_only();
        t_sweep();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule